// File: doc/BRIEF.md
# Count-and-Condition Branch Resolver

This block works out where execution goes after a conditional branch. A branch can depend on the 32-bit count register reaching zero or staying nonzero, on one condition bit selected by a mask, or on both together. The count register can drop by one as part of the same branch, and the zero test sees the count after that drop. The block also holds the link register. The taken target comes from an immediate, from an external register value, from the link register or from the count register. Any target read from a register has its two low address bits forced to zero.

The caller presents one branch per cycle with `op_valid`. Results appear on the next rising clock edge: the next address, a taken flag, and the updated count and link registers. Separate write strobes load the count and link registers directly, for example to set up a loop count or to store a return address.

Top module: `brres_top`

## Requirements
- R1: `br_mode` selects the condition. 0 is count≠0, 1 is count≠0 and hit, 2 is count≠0 and no hit, 3 is count=0, 4 is count=0 and hit, 5 is count=0 and no hit, 6 is hit, and 7 is no hit. "Hit" means that at least one bit set in `bit_mask` is also set in `cond_word`.
- R2: A valid branch with `dec_req`=1 lowers the count register by one modulo 2^32, so 0 becomes 0xFFFFFFFF.
- R3: The count test in modes 0 to 5 uses the count value after the decrement of the same branch.
- R4: On a taken branch, `next_addr` is the selected target. Targets taken from the external register, the link register or the count register have bits [1:0] cleared. An immediate target is used unchanged.
- R5: On a branch that is not taken, `next_addr` equals `fallthru_addr`.
- R6: `tgt_sel` picks the target source: 0 immediate, 1 external register, 2 link register, 3 count register. The link and count values used are the ones held before this cycle's writes and decrement.
- R7: When `link_wr_en`=1, `link_q` takes `link_wr_data` at the edge, in any cycle.
- R8: When `ctr_wr_en`=1, `ctr_q` takes `ctr_wr_data` at the edge. This load wins over a decrement in the same cycle.
- R9: Results register one edge after a valid branch, with `res_valid`=1. A cycle with `op_valid`=0 gives `res_valid`=0 and `taken`=0, and it leaves the count unchanged even if `dec_req` is 1 (unless a load is requested).
- R10: Reset clears the count register, the link register, `next_addr`, `taken` and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Branch present this cycle |
| br_mode | input | 3 | Condition code (R1) |
| cond_word | input | 32 | Condition bits |
| bit_mask | input | 32 | Selects the tested condition bit(s) |
| tgt_sel | input | 2 | Target source (R6) |
| imm_target | input | 32 | Immediate target address |
| reg_target | input | 32 | External register target address |
| fallthru_addr | input | 32 | Address used when not taken |
| dec_req | input | 1 | Decrement the count register with this branch |
| ctr_wr_en | input | 1 | Load the count register |
| ctr_wr_data | input | 32 | Count load value |
| link_wr_en | input | 1 | Load the link register |
| link_wr_data | input | 32 | Return address to store |
| res_valid | output | 1 | Result registered this cycle |
| taken | output | 1 | Branch condition met |
| next_addr | output | 32 | Resolved next address |
| ctr_q | output | 32 | Count register |
| link_q | output | 32 | Link register |

## Verification
The bench runs all eight modes with count values 0, 1 and 0xFFFFFFFF, each with and without a decrement and with the condition hit and missed. Count 1 with a decrement catches a design that tests the count before it drops: that design would call a zero count nonzero. Count 0 with a decrement catches a broken wrap. Unaligned link, count and external register targets expose a missing low-bit clear, and an unaligned immediate catches a design that clears bits it should keep. Other cases catch a design that reads a freshly written link or count value instead of the old one, one that lets a decrement beat a load, and one that decrements on an idle cycle.

// File: rtl/brres_pkg.sv
package brres_pkg;
   typedef enum logic [2:0] {
      M_CNZ     = 3'd0,
      M_CNZ_HIT = 3'd1,
      M_CNZ_MIS = 3'd2,
      M_CZ      = 3'd3,
      M_CZ_HIT  = 3'd4,
      M_CZ_MIS  = 3'd5,
      M_HIT     = 3'd6,
      M_MIS     = 3'd7
   } br_mode_e;

   typedef enum logic [1:0] {
      T_IMM  = 2'd0,
      T_REG  = 2'd1,
      T_LINK = 2'd2,
      T_CTR  = 2'd3
   } tgt_sel_e;
endpackage

// File: rtl/brres_cond_eval.sv
module brres_cond_eval
   import brres_pkg::*;
#(
   parameter int CRW     = 32,
   parameter int CW      = 32,
   parameter bit ANY_HIT = 1'b1
) (
   input  logic [CRW-1:0] cond_word,
   input  logic [CRW-1:0] bit_mask,
   input  br_mode_e       mode,
   input  logic [CW-1:0]  ctr_after,
   output logic           cond_ok
);
   logic hit;
   logic ctr_zero;

   generate
      if (ANY_HIT) begin : g_any
         assign hit = |(cond_word & bit_mask);
      end else begin : g_all
         assign hit = ((cond_word & bit_mask) == bit_mask) && (|bit_mask);
      end
   endgenerate

   assign ctr_zero = (ctr_after == '0);

   always_comb begin
      unique case (mode)
         M_CNZ:     cond_ok = !ctr_zero;
         M_CNZ_HIT: cond_ok = !ctr_zero && hit;
         M_CNZ_MIS: cond_ok = !ctr_zero && !hit;
         M_CZ:      cond_ok = ctr_zero;
         M_CZ_HIT:  cond_ok = ctr_zero && hit;
         M_CZ_MIS:  cond_ok = ctr_zero && !hit;
         M_HIT:     cond_ok = hit;
         M_MIS:     cond_ok = !hit;
         default:   cond_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/brres_ctr_unit.sv
module brres_ctr_unit #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic          dec_req,
   input  logic          ld_en,
   input  logic [CW-1:0] ld_val,
   output logic [CW-1:0] ctr_q,
   output logic [CW-1:0] ctr_after
);
   localparam logic [CW-1:0] ONE = CW'(1);

   assign ctr_after = (op_valid && dec_req) ? (ctr_q - ONE) : ctr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      ctr_q <= '0;
      else if (ld_en)  ctr_q <= ld_val;
      else             ctr_q <= ctr_after;
   end

   // R8
   ctr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> ctr_q == $past(ld_val));

   // R2
   ctr_dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && dec_req && !ld_en) |=> ctr_q == CW'($past(ctr_q) - ONE));

   // R9
   ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !ld_en) |=> $stable(ctr_q));
endmodule

// File: rtl/brres_target_sel.sv
module brres_target_sel
   import brres_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 32,
   parameter int ALIGN_BITS = 2
) (
   input  tgt_sel_e      sel,
   input  logic [AW-1:0] imm_target,
   input  logic [AW-1:0] reg_target,
   input  logic [AW-1:0] link_val,
   input  logic [CW-1:0] ctr_val,
   output logic [AW-1:0] target
);
   logic [AW-1:0] ctr_as_addr;
   logic [AW-1:0] reg_src;
   logic [AW-1:0] reg_aligned;

   generate
      if (CW >= AW) begin : g_ctr_trunc
         assign ctr_as_addr = ctr_val[AW-1:0];
      end else begin : g_ctr_ext
         assign ctr_as_addr = {{(AW-CW){1'b0}}, ctr_val};
      end
   endgenerate

   always_comb begin
      unique case (sel)
         T_REG:   reg_src = reg_target;
         T_LINK:  reg_src = link_val;
         default: reg_src = ctr_as_addr;
      endcase
   end

   generate
      if (ALIGN_BITS > 0) begin : g_align
         assign reg_aligned = {reg_src[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end else begin : g_noalign
         assign reg_aligned = reg_src;
      end
   endgenerate

   assign target = (sel == T_IMM) ? imm_target : reg_aligned;
endmodule

// File: rtl/brres_top.sv
module brres_top
   import brres_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 32,
   parameter int CRW        = 32,
   parameter int ALIGN_BITS = 2,
   parameter bit ANY_HIT    = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           op_valid,
   input  logic [2:0]     br_mode,
   input  logic [CRW-1:0] cond_word,
   input  logic [CRW-1:0] bit_mask,
   input  logic [1:0]     tgt_sel,
   input  logic [AW-1:0]  imm_target,
   input  logic [AW-1:0]  reg_target,
   input  logic [AW-1:0]  fallthru_addr,
   input  logic           dec_req,
   input  logic           ctr_wr_en,
   input  logic [CW-1:0]  ctr_wr_data,
   input  logic           link_wr_en,
   input  logic [AW-1:0]  link_wr_data,
   output logic           res_valid,
   output logic           taken,
   output logic [AW-1:0]  next_addr,
   output logic [CW-1:0]  ctr_q,
   output logic [AW-1:0]  link_q
);
   generate
      if (AW <= ALIGN_BITS) begin : g_bad_align
         $error("brres_top: AW must exceed ALIGN_BITS");
      end
      if (CW < 2) begin : g_bad_cw
         $error("brres_top: CW must be at least 2");
      end
      if (CRW < 1) begin : g_bad_crw
         $error("brres_top: CRW must be at least 1");
      end
   endgenerate

   logic [CW-1:0] ctr_after;
   logic          cond_ok;
   logic [AW-1:0] target;

   brres_ctr_unit #(.CW(CW)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .dec_req   (dec_req),
      .ld_en     (ctr_wr_en),
      .ld_val    (ctr_wr_data),
      .ctr_q     (ctr_q),
      .ctr_after (ctr_after)
   );

   brres_cond_eval #(.CRW(CRW), .CW(CW), .ANY_HIT(ANY_HIT)) u_cond (
      .cond_word (cond_word),
      .bit_mask  (bit_mask),
      .mode      (br_mode_e'(br_mode)),
      .ctr_after (ctr_after),
      .cond_ok   (cond_ok)
   );

   brres_target_sel #(.AW(AW), .CW(CW), .ALIGN_BITS(ALIGN_BITS)) u_tgt (
      .sel        (tgt_sel_e'(tgt_sel)),
      .imm_target (imm_target),
      .reg_target (reg_target),
      .link_val   (link_q),
      .ctr_val    (ctr_q),
      .target     (target)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          link_q <= '0;
      else if (link_wr_en) link_q <= link_wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         taken     <= 1'b0;
         next_addr <= '0;
      end else if (op_valid) begin
         res_valid <= 1'b1;
         taken     <= cond_ok;
         next_addr <= cond_ok ? target : fallthru_addr;
      end else begin
         res_valid <= 1'b0;
         taken     <= 1'b0;
      end
   end

   // R5
   fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (taken || next_addr == $past(fallthru_addr)));

   // R4
   imm_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && tgt_sel == 2'd0) |=> (!taken || next_addr == $past(imm_target)));

   generate
      if (ALIGN_BITS > 0) begin : g_align_chk
         // R4
         reg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && tgt_sel != 2'd0) |=> (!taken || next_addr[ALIGN_BITS-1:0] == '0));
      end
   endgenerate

   // R3
   dec_then_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && dec_req && br_mode == 3'd3 && ctr_q == CW'(1)) |=> taken);

   // R7
   link_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_wr_en |=> link_q == $past(link_wr_data));

   // R9
   idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!res_valid && !taken));

   // R9
   valid_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);
endmodule

// File: tb/brres_top_tb.sv
module brres_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  br_mode = '0;
   logic [31:0] cond_word = '0;
   logic [31:0] bit_mask = '0;
   logic [1:0]  tgt_sel = '0;
   logic [31:0] imm_target = '0;
   logic [31:0] reg_target = '0;
   logic [31:0] fallthru_addr = '0;
   logic        dec_req = 1'b0;
   logic        ctr_wr_en = 1'b0;
   logic [31:0] ctr_wr_data = '0;
   logic        link_wr_en = 1'b0;
   logic [31:0] link_wr_data = '0;
   logic        res_valid;
   logic        taken;
   logic [31:0] next_addr;
   logic [31:0] ctr_q;
   logic [31:0] link_q;

   int tests_run = 0;
   int tests_failed = 0;

   always #4 clk = ~clk;

   brres_top u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .br_mode(br_mode),
      .cond_word(cond_word), .bit_mask(bit_mask), .tgt_sel(tgt_sel),
      .imm_target(imm_target), .reg_target(reg_target),
      .fallthru_addr(fallthru_addr), .dec_req(dec_req),
      .ctr_wr_en(ctr_wr_en), .ctr_wr_data(ctr_wr_data),
      .link_wr_en(link_wr_en), .link_wr_data(link_wr_data),
      .res_valid(res_valid), .taken(taken), .next_addr(next_addr),
      .ctr_q(ctr_q), .link_q(link_q)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests_run++;
      if (act !== exp) begin
         tests_failed++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic exp_taken(input int m, input logic [31:0] c, input logic hit);
      logic nz = (c != 32'd0);
      case (m)
         0: return nz;
         1: return nz && hit;
         2: return nz && !hit;
         3: return !nz;
         4: return !nz && hit;
         5: return !nz && !hit;
         6: return hit;
         default: return !hit;
      endcase
   endfunction

   task automatic load_ctr(input logic [31:0] v);
      @(negedge clk);
      ctr_wr_en = 1'b1; ctr_wr_data = v;
      @(negedge clk);
      ctr_wr_en = 1'b0;
   endtask

   task automatic load_link(input logic [31:0] v);
      @(negedge clk);
      link_wr_en = 1'b1; link_wr_data = v;
      @(negedge clk);
      link_wr_en = 1'b0;
   endtask

   task automatic branch(input logic [2:0] m, input logic dec, input logic [31:0] cw,
                         input logic [31:0] msk, input logic [1:0] sel);
      @(negedge clk);
      op_valid = 1'b1; br_mode = m; dec_req = dec; cond_word = cw;
      bit_mask = msk; tgt_sel = sel;
      @(negedge clk);
      op_valid = 1'b0; dec_req = 1'b0;
   endtask

   task automatic test_reset();
      check("R10 ctr", ctr_q, 32'd0);
      check("R10 link", link_q, 32'd0);
      check("R10 next_addr", next_addr, 32'd0);
      check("R10 flags", {30'd0, res_valid, taken}, 32'd0);
   endtask

   // R1 R2 R3 R5: every mode against count 0, 1 and all-ones
   task automatic test_modes();
      logic [31:0] vals [3] = '{32'd0, 32'd1, 32'hFFFF_FFFF};
      imm_target = 32'h0000_4001;
      fallthru_addr = 32'h0000_0104;
      for (int v = 0; v < 3; v++)
         for (int m = 0; m < 8; m++)
            for (int d = 0; d < 2; d++)
               for (int h = 0; h < 2; h++) begin
                  logic [31:0] after;
                  logic et;
                  load_ctr(vals[v]);
                  after = (d != 0) ? vals[v] - 32'd1 : vals[v];
                  et = exp_taken(m, after, h != 0);
                  branch(3'(m), d != 0, (h != 0) ? 32'h0000_0100 : 32'h0000_0400,
                         32'h0000_0300, 2'd0);
                  check($sformatf("R1 R3 taken m=%0d c=%h d=%0d h=%0d", m, vals[v], d, h),
                        {31'd0, taken}, {31'd0, et});
                  check("R4 R5 next_addr", next_addr, et ? 32'h0000_4001 : 32'h0000_0104);
                  check("R2 ctr after", ctr_q, after);
                  check("R9 res_valid", {31'd0, res_valid}, 32'd1);
               end
   endtask

   // R4 R6: register sourced targets are aligned and read before updates
   task automatic test_targets();
      fallthru_addr = 32'h0000_0200;
      reg_target = 32'h0000_5557;
      branch(3'd6, 1'b0, 32'h1, 32'h1, 2'd1);
      check("R4 ext reg aligned", next_addr, 32'h0000_5554);
      load_link(32'h0000_2002);
      @(negedge clk);
      op_valid = 1'b1; br_mode = 3'd6; cond_word = 32'h1; bit_mask = 32'h1; tgt_sel = 2'd2;
      link_wr_en = 1'b1; link_wr_data = 32'h0000_3000;
      @(negedge clk);
      op_valid = 1'b0; link_wr_en = 1'b0;
      check("R6 link old value", next_addr, 32'h0000_2000);
      check("R7 link written", link_q, 32'h0000_3000);
      load_ctr(32'h0000_1007);
      branch(3'd0, 1'b1, 32'h0, 32'h0, 2'd3);
      check("R6 ctr pre-dec target", next_addr, 32'h0000_1004);
      check("R2 ctr dec", ctr_q, 32'h0000_1006);
   endtask

   // R8 R9: load beats decrement, idle leaves count alone
   task automatic test_ctr_rules();
      load_ctr(32'd50);
      @(negedge clk);
      op_valid = 1'b1; br_mode = 3'd0; dec_req = 1'b1; tgt_sel = 2'd0;
      ctr_wr_en = 1'b1; ctr_wr_data = 32'd9;
      @(negedge clk);
      op_valid = 1'b0; dec_req = 1'b0; ctr_wr_en = 1'b0;
      check("R8 load wins", ctr_q, 32'd9);
      @(negedge clk);
      dec_req = 1'b1;
      @(negedge clk);
      dec_req = 1'b0;
      check("R9 idle ctr", ctr_q, 32'd9);
      check("R9 idle flags", {30'd0, res_valid, taken}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_modes();
      test_targets();
      test_ctr_rules();
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      #(8 * 150000);
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end
endmodule